// File: doc/BRIEF.md
# Pseudo-LRU Data Micro-TLB

This block is a four-entry, fully associative translation cache placed in front of the joint TLB on the data side. A lookup presents a virtual address and an address-space identifier. If an entry matches, the block returns the physical address and the page attribute in the same cycle. Pages are 4 KB, so the page offset passes through unchanged. Software cannot see the block: it holds no registers and keeps itself filled.

When a lookup misses, the block raises a refill request toward the joint TLB. The request carries the missed page number and identifier and stays up until the response arrives. Lookups stall while the request is outstanding. The returned mapping is written into a victim entry. An empty entry is used first. When all entries are valid, a three-bit tree chooses the older entry inside the older half. A flush input empties the buffer in one cycle. The surrounding logic asserts it when the joint TLB contents or the current identifier change.

Top module: `dtlb_micro`

## Requirements
- R1: After reset no entry is valid, `lk_hit` is 0 and `rq_valid` is 0.
- R2: When `lk_valid` is 1, `flush` is 0 and no refill is outstanding, a valid entry whose page number equals `lk_vaddr[31:12]` matches. `lk_hit` is then 1 in the same cycle, `lk_paddr` = {entry frame, `lk_vaddr[11:0]`} and `lk_attr` is the entry attribute.
- R3: A non-global entry matches only when its stored identifier equals `lk_asid`. An entry written with `rf_global`=1 matches under any identifier.
- R4: An accepted lookup that misses sets `rq_valid` from the next cycle. `rq_vpn` and `rq_asid` then hold the missed page number and identifier, and they stay unchanged until a response or a flush.
- R5: While `rq_valid` is 1, lookups are stalled. `lk_hit` stays 0 and no second request is started.
- R6: `rf_valid` with `rq_valid`=1 writes {`rf_vpn`, `rf_asid`, `rf_global`, `rf_pfn`, `rf_attr`} into the victim and clears `rq_valid` the next cycle. A later lookup of that page hits. `rf_valid` with no outstanding request is ignored.
- R7: While an entry is invalid, the refill goes to the lowest-numbered invalid entry.
- R8: When all four entries are valid, the victim is entry {top, half[top]}. Each hit or fill of entry i sets top to the inverse of i[1] and half[i[1]] to the inverse of i[0]. Reset clears all three bits.
- R9: `flush` invalidates every entry and cancels an outstanding request in one cycle. In the flush cycle `lk_hit` is 0, no request is started, and a refill response arriving in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| flush | input | 1 | Invalidate all entries and cancel any pending refill |
| rf_valid | input | 1 | Refill response from the joint TLB is valid |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_asid | input | 8 | Refill identifier |
| rf_global | input | 1 | Refill mapping ignores the identifier |
| rf_pfn | input | 24 | Refill physical frame number |
| rf_attr | input | 3 | Refill page attribute |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_paddr | output | 36 | Translated physical address (0 when no hit) |
| lk_attr | output | 3 | Attribute of the matching entry (0 when no hit) |
| rq_valid | output | 1 | Refill request outstanding |
| rq_vpn | output | 20 | Page number of the outstanding request |
| rq_asid | output | 8 | Identifier of the outstanding request |

## Verification
Two events can fall in the same cycle: a flush and the refill response for the outstanding request. The bench drives both together while a request is pending. It then checks that `rq_valid` drops, and that a following lookup of the page that was being refilled misses. A miss shows that flush took priority and the returned mapping was discarded. Random traffic also pulses flush at arbitrary points while refills are pending. A bench model checks every cycle in which a lookup, a stall or a spurious response meets that pulse.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int NENT  = 4;
    localparam int IDX_W = $clog2(NENT);

    // top = 0 : half 0 holds the older pair
    // half[h] = 0 : the lower entry of half h is older
    typedef struct packed {
        logic       top;
        logic [1:0] half;
    } plru_t;

    function automatic plru_t plru_touch(plru_t s, logic [IDX_W-1:0] idx);
        plru_t n;
        n             = s;
        n.top         = ~idx[1];
        n.half[idx[1]] = ~idx[0];
        return n;
    endfunction

    function automatic logic [IDX_W-1:0] plru_pick(plru_t s);
        return {s.top, s.half[s.top]};
    endfunction

endpackage

// File: rtl/dtlb_cam.sv
module dtlb_cam #(
    parameter int NENT   = 4,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    localparam int IW    = $clog2(NENT)
) (
    input  logic [NENT-1:0]             vld,
    input  logic [NENT-1:0]             glob,
    input  logic [NENT-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [NENT-1:0][ASID_W-1:0] tag_asid,
    input  logic [VPN_W-1:0]            key_vpn,
    input  logic [ASID_W-1:0]           key_asid,
    output logic                        hit,
    output logic [IW-1:0]               hit_idx
);

    logic [NENT-1:0] match;

    for (genvar i = 0; i < NENT; i++) begin : g_cmp
        assign match[i] = vld[i] && (tag_vpn[i] == key_vpn) &&
                          (glob[i] || (tag_asid[i] == key_asid));
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
        end
        hit = |match;
    end

endmodule

// File: rtl/dtlb_plru.sv
module dtlb_plru
    import dtlb_pkg::*;
(
    input  plru_t            cur,
    input  logic [NENT-1:0]  vld,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim,
    output plru_t            nxt
);

    always_comb begin
        victim = plru_pick(cur);
        for (int i = NENT - 1; i >= 0; i--) begin
            if (!vld[i]) victim = IDX_W'(i);
        end
        nxt = touch_en ? plru_touch(cur, touch_idx) : cur;
    end

endmodule

// File: rtl/dtlb_micro.sv
module dtlb_micro
    import dtlb_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 36,
    parameter int OFS_W  = 12,
    parameter int ASID_W = 8,
    parameter int ATTR_W = 3,
    localparam int VPN_W = VA_W - OFS_W,
    localparam int PFN_W = PA_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              flush,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic              rf_global,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [ATTR_W-1:0] rf_attr,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              rq_valid,
    output logic [VPN_W-1:0]  rq_vpn,
    output logic [ASID_W-1:0] rq_asid
);

    typedef struct packed {
        logic [NENT-1:0]              vld;
        logic [NENT-1:0]              glob;
        logic [NENT-1:0][VPN_W-1:0]   vpn;
        logic [NENT-1:0][ASID_W-1:0]  asid;
        logic [NENT-1:0][PFN_W-1:0]   pfn;
        logic [NENT-1:0][ATTR_W-1:0]  attr;
        plru_t                        plru;
        logic                         pend;
        logic [VPN_W-1:0]             rvpn;
        logic [ASID_W-1:0]            rasid;
    } state_t;

    state_t s_q, s_d;

    logic             cam_hit;
    logic [IDX_W-1:0] cam_idx;
    logic [IDX_W-1:0] victim;
    logic             accept_d;
    logic             fill_d;
    logic             touch_d;
    logic [IDX_W-1:0] touch_idx_d;
    plru_t            plru_nxt;

    dtlb_cam #(
        .NENT   (NENT),
        .VPN_W  (VPN_W),
        .ASID_W (ASID_W)
    ) u_cam (
        .vld      (s_q.vld),
        .glob     (s_q.glob),
        .tag_vpn  (s_q.vpn),
        .tag_asid (s_q.asid),
        .key_vpn  (lk_vaddr[VA_W-1:OFS_W]),
        .key_asid (lk_asid),
        .hit      (cam_hit),
        .hit_idx  (cam_idx)
    );

    dtlb_plru u_plru (
        .cur       (s_q.plru),
        .vld       (s_q.vld),
        .touch_en  (touch_d),
        .touch_idx (touch_idx_d),
        .victim    (victim),
        .nxt       (plru_nxt)
    );

    always_comb begin
        accept_d    = lk_valid && !flush && !s_q.pend;
        fill_d      = s_q.pend && rf_valid && !flush;
        lk_hit      = accept_d && cam_hit;
        touch_d     = lk_hit || fill_d;
        touch_idx_d = fill_d ? victim : cam_idx;

        lk_paddr = '0;
        lk_attr  = '0;
        if (lk_hit) begin
            lk_paddr = {s_q.pfn[cam_idx], lk_vaddr[OFS_W-1:0]};
            lk_attr  = s_q.attr[cam_idx];
        end

        s_d      = s_q;
        s_d.plru = plru_nxt;
        if (flush) begin
            s_d.vld  = '0;
            s_d.pend = 1'b0;
        end else if (fill_d) begin
            s_d.vld[victim]  = 1'b1;
            s_d.glob[victim] = rf_global;
            s_d.vpn[victim]  = rf_vpn;
            s_d.asid[victim] = rf_asid;
            s_d.pfn[victim]  = rf_pfn;
            s_d.attr[victim] = rf_attr;
            s_d.pend         = 1'b0;
        end else if (accept_d && !cam_hit) begin
            s_d.pend  = 1'b1;
            s_d.rvpn  = lk_vaddr[VA_W-1:OFS_W];
            s_d.rasid = lk_asid;
        end

        rq_valid = s_q.pend;
        rq_vpn   = s_q.rvpn;
        rq_asid  = s_q.rasid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/dtlb_micro_chk.sv
module dtlb_micro_chk #(
    parameter int VPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             flush,
    input logic             rf_valid,
    input logic             lk_hit,
    input logic             rq_valid,
    input logic [VPN_W-1:0] rq_vpn
);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && !rf_valid && !flush) |=> (rq_valid && $stable(rq_vpn)));

    p_miss_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !rq_valid && !flush && !lk_hit) |=> rq_valid);

    p_stall_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |-> !lk_hit);

    p_rsp_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rf_valid) |=> !rq_valid);

    p_hit_needs_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_valid && !flush));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rq_valid && !(lk_hit && $past(flush))));

endmodule

bind dtlb_micro dtlb_micro_chk #(.VPN_W(VPN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .flush    (flush),
    .rf_valid (rf_valid),
    .lk_hit   (lk_hit),
    .rq_valid (rq_valid),
    .rq_vpn   (rq_vpn)
);

// File: tb/tb_dtlb_micro.sv
`timescale 1ns/1ps
module tb_dtlb_micro;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lv = 1'b0, fl = 1'b0, rv = 1'b0, rg = 1'b0;
    logic [31:0] va = '0;
    logic [7:0]  asid = '0, rasid = '0;
    logic [19:0] rvpn = '0;
    logic [23:0] rpfn = '0;
    logic [2:0]  rattr = '0;
    logic        lk_hit, rq_valid;
    logic [35:0] lk_paddr;
    logic [2:0]  lk_attr;
    logic [19:0] rq_vpn;
    logic [7:0]  rq_asid;

    always #5 clk = ~clk;

    dtlb_micro dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lv), .lk_vaddr(va), .lk_asid(asid),
        .flush(fl), .rf_valid(rv), .rf_vpn(rvpn), .rf_asid(rasid),
        .rf_global(rg), .rf_pfn(rpfn), .rf_attr(rattr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
        .rq_valid(rq_valid), .rq_vpn(rq_vpn), .rq_asid(rq_asid)
    );

    int n_chk = 0, n_bad = 0;

    // bench model of the requirements
    logic        m_vld [4];
    logic        m_g   [4];
    logic [19:0] m_vpn [4];
    logic [7:0]  m_asid[4];
    logic [23:0] m_pfn [4];
    logic [2:0]  m_attr[4];
    logic        m_top;
    logic [1:0]  m_half;
    logic        m_pend;
    logic [19:0] m_rvpn;
    logic [7:0]  m_rasid;

    // outputs sampled in the last cycle
    logic        s_hit, s_rq;
    logic [35:0] s_pa;
    logic [19:0] s_rqvpn;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
        end
    endtask

    function automatic int m_find(logic [19:0] v, logic [7:0] a);
        for (int i = 0; i < 4; i++)
            if (m_vld[i] && m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < 4; i++) if (!m_vld[i]) return i;
        return m_top ? (2 + int'(m_half[1])) : int'(m_half[0]);
    endfunction

    task automatic m_touch(input int e);
        m_top = (e < 2);
        m_half[e / 2] = ((e % 2) == 0);
    endtask

    task automatic m_reset();
        for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
        m_top = 1'b0; m_half = 2'b00; m_pend = 1'b0;
    endtask

    task automatic idle();
        lv = 1'b0; fl = 1'b0; rv = 1'b0;
    endtask

    // inputs are set right after a falling edge; check, clock, update model
    task automatic cyc();
        int  e;
        logic acc;
        #2;
        acc = lv && !fl && !m_pend;
        e   = m_find(va[31:12], asid);
        s_hit = lk_hit; s_pa = lk_paddr; s_rq = rq_valid; s_rqvpn = rq_vpn;
        chk("R2", "hit", lk_hit, acc && e >= 0);
        if (acc && e >= 0) begin
            chk("R2", "paddr", lk_paddr, {m_pfn[e], va[11:0]});
            chk("R2", "attr", lk_attr, m_attr[e]);
        end
        chk("R4", "rq_valid", rq_valid, m_pend);
        if (m_pend) begin
            chk("R4", "rq_vpn", rq_vpn, m_rvpn);
            chk("R4", "rq_asid", rq_asid, m_rasid);
        end
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
            m_pend = 1'b0;
        end else if (m_pend && rv) begin
            e = m_victim();
            m_vld[e] = 1'b1; m_g[e] = rg; m_vpn[e] = rvpn; m_asid[e] = rasid;
            m_pfn[e] = rpfn; m_attr[e] = rattr;
            m_touch(e);
            m_pend = 1'b0;
        end else if (acc) begin
            if (e >= 0) m_touch(e);
            else begin m_pend = 1'b1; m_rvpn = va[31:12]; m_rasid = asid; end
        end
        @(negedge clk);
        idle();
    endtask

    task automatic look(input logic [19:0] v, input logic [7:0] a, input logic [11:0] off);
        lv = 1'b1; va = {v, off}; asid = a;
        cyc();
    endtask

    task automatic respond(input logic [19:0] v, input logic [7:0] a, input logic g,
                           input logic [23:0] pfn, input logic [2:0] at);
        rv = 1'b1; rvpn = v; rasid = a; rg = g; rpfn = pfn; rattr = at;
        cyc();
    endtask

    task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic g,
                        input logic [23:0] pfn, input logic [2:0] at);
        look(v, a, 12'h000);
        respond(v, a, g, pfn, at);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        #2;
        chk("R1", "hit after reset", lk_hit, 0);
        chk("R1", "rq_valid after reset", rq_valid, 0);
        @(negedge clk);

        // R7 fill empty entries in order 0..3
        fill(20'h00100, 8'd1, 1'b0, 24'h000A00, 3'd3);
        fill(20'h00101, 8'd1, 1'b0, 24'h000B00, 3'd1);
        fill(20'h00102, 8'd1, 1'b0, 24'h000C00, 3'd2);
        fill(20'h00103, 8'd1, 1'b0, 24'h000D00, 3'd5);
        look(20'h00100, 8'd1, 12'h5A5);
        chk("R2", "direct hit", s_hit, 1);
        chk("R2", "direct paddr", s_pa, 36'h000A005A5);
        // R7 R8: after fills 0..3 and a hit on 0, the victim is entry 2
        fill(20'h00104, 8'd1, 1'b0, 24'h000E00, 3'd0);
        look(20'h00100, 8'd1, 12'h001);
        chk("R8", "survivor entry 0", s_hit, 1);
        look(20'h00102, 8'd1, 12'h002);
        chk("R8", "entry 2 evicted", s_hit, 0);
        // R5 stall while refill pending
        look(20'h00101, 8'd1, 12'h003);
        chk("R5", "stalled lookup no hit", s_hit, 0);
        chk("R5", "request unchanged", s_rqvpn, 20'h00102);
        // R9 flush together with the refill response
        fl = 1'b1; rv = 1'b1; rvpn = 20'h00102; rasid = 8'd1; rg = 1'b0;
        rpfn = 24'h000C11; rattr = 3'd2;
        cyc();
        look(20'h00102, 8'd1, 12'h004);
        chk("R9", "request cancelled", s_rq, 0);
        chk("R9", "refill discarded", s_hit, 0);
        respond(20'h00102, 8'd1, 1'b0, 24'h000C22, 3'd4);
        look(20'h00100, 8'd1, 12'h000);
        chk("R9", "old entry flushed", s_hit, 0);
        respond(20'h00100, 8'd1, 1'b0, 24'h000A11, 3'd3);
        // R3 identifier rules
        look(20'h00100, 8'd2, 12'h010);
        chk("R3", "other asid misses", s_hit, 0);
        respond(20'h00100, 8'd2, 1'b0, 24'h000A22, 3'd3);
        fill(20'h00105, 8'd1, 1'b1, 24'h000F00, 3'd6);
        look(20'h00105, 8'd77, 12'h020);
        chk("R3", "global hits any asid", s_hit, 1);
        // R6 stray response ignored
        respond(20'h001FF, 8'd1, 1'b0, 24'h000123, 3'd1);
        look(20'h001FF, 8'd1, 12'h030);
        chk("R6", "stray response ignored", s_hit, 0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            fl = (($urandom % 64) == 0);
            if (m_pend) rv = (($urandom % 3) == 0);
            else        rv = (($urandom % 16) == 0);
            rvpn  = m_pend ? m_rvpn  : 20'h00300 + 20'($urandom % 6);
            rasid = m_pend ? m_rasid : 8'd1;
            rg    = (($urandom % 4) == 0);
            rpfn  = 24'($urandom);
            rattr = 3'($urandom);
            lv    = (($urandom % 4) != 0);
            va    = {20'h00300 + 20'($urandom % 6), 12'($urandom)};
            asid  = 8'(1 + ($urandom % 2));
            cyc();
        end
        summary();
        $finish;
    end

endmodule